// File: doc/BRIEF.md
# Gated Environment-Configuration CSR Unit

This block holds the supervisor and hypervisor environment-configuration registers of a RISC-V hart, together with three state-enable registers: one each for machine, hypervisor and supervisor level. Each state-enable register carries a bit that opens the environment-configuration registers to the level below it. A CSR access request arrives with a 12-bit address, a read/write flag, 64-bit write data, the current privilege, a virtualization flag and an XLEN-mode flag. In the same cycle the block returns either the read data or an exception cause. A write that is accepted takes effect at the next clock edge.

Every access to an environment-configuration register passes through a three-level permission check. The machine-level enable is checked first. The hypervisor-level enable is checked only when the hart runs virtualized. The supervisor-level enable is checked only for a user-mode access. The first level that blocks the access decides the exception cause. A parameter can remove the gate entirely, and then every access is let through. Writes change only the architected fields of each register. The state-enable registers accept only their two defined bits.

Top module: `envcfg_gate_csr`

## Requirements
- R1: After reset, all five registers read as zero.
- R2: With `GATE_EN` = 0, no access to an environment-configuration register raises an exception.
- R3: An environment-configuration access with bit 62 of the machine state-enable register (0x30C) clear raises cause 2 (illegal instruction) in the same cycle as the request. This check takes priority over the checks in R4 and R5.
- R4: With the machine enable set, a virtualized access with bit 62 of the hypervisor state-enable register (0x60C) clear raises cause 22 (virtual instruction).
- R5: With the machine enable set, and the hypervisor enable also set when virtualized, a user-mode access (priv 0) with bit 62 of the supervisor state-enable register (0x10C) clear raises cause 2.
- R6: An access that raises an exception changes no register and returns zero read data.
- R7: A write to the supervisor config register (0x10A) updates only bits 0, 4, 5, 6 and 7.
- R8: A write to the hypervisor config register (0x60A) updates bits 0 and 4 to 7. In RV64 mode (`req_xlen64` = 1) it also updates bits 62 and 63.
- R9: A read of 0x61A returns bits 63:32 of the hypervisor config register. A write to 0x61A sets bits 62 and 63 from write-data bits 30 and 31 and leaves every other bit unchanged.
- R10: In the state-enable registers only bits 63 and 62 can be written. The machine register is written through 0x30C and its high half through 0x31C. The hypervisor register is written through 0x60C and its high half through 0x61C. The supervisor register is written through 0x10C. The state-enable registers themselves are never gated.
- R11: In RV32 mode, an access to a low-half address reads bits 31:0, zero-extended, and a write touches only bits 31:0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 12 | CSR address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Hart is running virtualized |
| req_xlen64 | input | 1 | 1 = RV64 mode, 0 = RV32 mode |
| rsp_rdata | output | 64 | Read data, zero when faulting |
| rsp_exc | output | 1 | Access raises an exception |
| rsp_cause | output | 5 | Exception cause (2 or 22), zero otherwise |

## Verification
The hardest case to reach is a blocked access where more than one enable level would block it. Only the priority order then decides which cause is seen, and only a register that stays unchanged shows that nothing was written. The stimulus first programs all three enable registers through their own ungated addresses. It then sweeps all eight enable patterns against every privilege, virtualization state, XLEN mode and target register. After each pattern it opens all gates and reads the configuration registers back, which shows that every faulting write left them untouched.

// File: rtl/envgate_pkg.sv
package envgate_pkg;
    localparam int XW = 64;

    localparam logic [11:0] A_ENV_S   = 12'h10A;
    localparam logic [11:0] A_EN_S    = 12'h10C;
    localparam logic [11:0] A_EN_M    = 12'h30C;
    localparam logic [11:0] A_EN_MH   = 12'h31C;
    localparam logic [11:0] A_ENV_H   = 12'h60A;
    localparam logic [11:0] A_ENV_HH  = 12'h61A;
    localparam logic [11:0] A_EN_H    = 12'h60C;
    localparam logic [11:0] A_EN_HH   = 12'h61C;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [4:0] CAUSE_ILL  = 5'd2;
    localparam logic [4:0] CAUSE_VIRT = 5'd22;

    // architected config fields: low byte fields and upper-word fields
    localparam logic [XW-1:0] ENV_LO_MASK = 64'h0000_0000_0000_00F1;
    localparam logic [XW-1:0] ENV_HI_MASK = 64'hC000_0000_0000_0000;

    typedef enum logic [3:0] {
        T_NONE, T_ENV_S, T_ENV_H, T_ENV_HH,
        T_EN_M, T_EN_MH, T_EN_H, T_EN_HH, T_EN_S
    } tgt_e;

    typedef struct packed {
        logic [XW-1:0] env_s;
        logic [XW-1:0] env_h;
        logic [XW-1:0] en_m;
        logic [XW-1:0] en_h;
        logic [XW-1:0] en_s;
    } gate_state_t;
endpackage

// File: rtl/envgate_decode.sv
module envgate_decode
    import envgate_pkg::*;
(
    input  logic [11:0] addr,
    output tgt_e        tgt,
    output logic        is_env
);
    always_comb begin
        unique case (addr)
            A_ENV_S:  tgt = T_ENV_S;
            A_ENV_H:  tgt = T_ENV_H;
            A_ENV_HH: tgt = T_ENV_HH;
            A_EN_M:   tgt = T_EN_M;
            A_EN_MH:  tgt = T_EN_MH;
            A_EN_H:   tgt = T_EN_H;
            A_EN_HH:  tgt = T_EN_HH;
            A_EN_S:   tgt = T_EN_S;
            default:  tgt = T_NONE;
        endcase
        is_env = (tgt == T_ENV_S) || (tgt == T_ENV_H) || (tgt == T_ENV_HH);
    end
endmodule

// File: rtl/envgate_perm.sv
module envgate_perm
    import envgate_pkg::*;
#(
    parameter bit GATE_EN  = 1'b1,
    parameter int GATE_BIT = 62
) (
    input  logic          is_env,
    input  logic [XW-1:0] en_m,
    input  logic [XW-1:0] en_h,
    input  logic [XW-1:0] en_s,
    input  logic [1:0]    priv,
    input  logic          virt,
    output logic          exc,
    output logic [4:0]    cause
);
    generate
        if (GATE_EN) begin : g_gate
            // ordered: machine level, then hypervisor (virt only), then user
            always_comb begin
                exc   = 1'b0;
                cause = 5'd0;
                if (is_env) begin
                    if (!en_m[GATE_BIT]) begin
                        exc   = 1'b1;
                        cause = CAUSE_ILL;
                    end else if (virt && !en_h[GATE_BIT]) begin
                        exc   = 1'b1;
                        cause = CAUSE_VIRT;
                    end else if (priv == PRIV_U && !en_s[GATE_BIT]) begin
                        exc   = 1'b1;
                        cause = CAUSE_ILL;
                    end
                end
            end
        end else begin : g_open
            logic unused_in;
            assign unused_in = ^{is_env, en_m, en_h, en_s, priv, virt};
            assign exc   = 1'b0;
            assign cause = 5'd0;
        end
    endgenerate
endmodule

// File: rtl/envgate_access.sv
module envgate_access
    import envgate_pkg::*;
#(
    parameter int GATE_BIT  = 62,
    parameter int STATE_BIT = 63
) (
    input  tgt_e          tgt,
    input  logic [XW-1:0] wdata,
    input  logic          x64,
    input  gate_state_t   cur,
    output logic [XW-1:0] rdata,
    output gate_state_t   upd
);
    localparam int HW = XW / 2;
    localparam logic [XW-1:0] EN_MASK =
        (64'd1 << STATE_BIT) | (64'd1 << GATE_BIT);
    localparam logic [XW-1:0] LOW_WORD = {{HW{1'b0}}, {HW{1'b1}}};

    function automatic logic [XW-1:0] merge(input logic [XW-1:0] old_v,
                                            input logic [XW-1:0] new_v,
                                            input logic [XW-1:0] msk);
        return (old_v & ~msk) | (new_v & msk);
    endfunction

    logic [XW-1:0] lo_lane;  // lanes a low-half write may touch
    logic [XW-1:0] hi_val;   // write data placed in the upper word
    logic [XW-1:0] raw;

    always_comb begin
        lo_lane = x64 ? {XW{1'b1}} : LOW_WORD;
        hi_val  = {wdata[HW-1:0], {HW{1'b0}}};
        upd     = cur;
        raw     = '0;
        unique case (tgt)
            T_ENV_S: begin
                raw       = cur.env_s;
                upd.env_s = merge(cur.env_s, wdata, ENV_LO_MASK & lo_lane);
            end
            T_ENV_H: begin
                raw       = cur.env_h;
                upd.env_h = merge(cur.env_h, wdata,
                                  (ENV_LO_MASK | ENV_HI_MASK) & lo_lane);
            end
            T_ENV_HH: begin
                raw       = {{HW{1'b0}}, cur.env_h[XW-1:HW]};
                upd.env_h = merge(cur.env_h, hi_val, ENV_HI_MASK);
            end
            T_EN_M: begin
                raw      = cur.en_m;
                upd.en_m = merge(cur.en_m, wdata, EN_MASK & lo_lane);
            end
            T_EN_MH: begin
                raw      = {{HW{1'b0}}, cur.en_m[XW-1:HW]};
                upd.en_m = merge(cur.en_m, hi_val, EN_MASK);
            end
            T_EN_H: begin
                raw      = cur.en_h;
                upd.en_h = merge(cur.en_h, wdata, EN_MASK & lo_lane);
            end
            T_EN_HH: begin
                raw      = {{HW{1'b0}}, cur.en_h[XW-1:HW]};
                upd.en_h = merge(cur.en_h, hi_val, EN_MASK);
            end
            T_EN_S: begin
                raw      = cur.en_s;
                upd.en_s = merge(cur.en_s, wdata, EN_MASK & lo_lane);
            end
            default: raw = '0;
        endcase
        // high-half addresses already return a zero-extended word
        rdata = raw & lo_lane;
    end
endmodule

// File: rtl/envcfg_gate_csr.sv
module envcfg_gate_csr
    import envgate_pkg::*;
#(
    parameter bit GATE_EN   = 1'b1,
    parameter int GATE_BIT  = 62,
    parameter int STATE_BIT = 63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [11:0]   req_addr,
    input  logic          req_write,
    input  logic [XW-1:0] req_wdata,
    input  logic [1:0]    req_priv,
    input  logic          req_virt,
    input  logic          req_xlen64,
    output logic [XW-1:0] rsp_rdata,
    output logic          rsp_exc,
    output logic [4:0]    rsp_cause
);
    localparam logic [XW-1:0] EN_MASK =
        (64'd1 << STATE_BIT) | (64'd1 << GATE_BIT);

    gate_state_t   state_d, state_q, state_w;
    tgt_e          tgt;
    logic          is_env;
    logic          perm_exc;
    logic [4:0]    perm_cause;
    logic [XW-1:0] acc_rdata;

    envgate_decode u_decode (
        .addr   (req_addr),
        .tgt    (tgt),
        .is_env (is_env)
    );

    envgate_perm #(.GATE_EN(GATE_EN), .GATE_BIT(GATE_BIT)) u_perm (
        .is_env (is_env),
        .en_m   (state_q.en_m),
        .en_h   (state_q.en_h),
        .en_s   (state_q.en_s),
        .priv   (req_priv),
        .virt   (req_virt),
        .exc    (perm_exc),
        .cause  (perm_cause)
    );

    envgate_access #(.GATE_BIT(GATE_BIT), .STATE_BIT(STATE_BIT)) u_access (
        .tgt   (tgt),
        .wdata (req_wdata),
        .x64   (req_xlen64),
        .cur   (state_q),
        .rdata (acc_rdata),
        .upd   (state_w)
    );

    always_comb begin
        state_d   = state_q;
        rsp_exc   = req_valid && perm_exc;
        rsp_cause = rsp_exc ? perm_cause : 5'd0;
        rsp_rdata = (req_valid && !perm_exc) ? acc_rdata : '0;
        if (req_valid && req_write && !perm_exc)
            state_d = state_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R6: a faulting access leaves every register as it was
    assert_fault_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_exc) |=> (state_q == $past(state_q)));

    // R4: the virtual cause needs virtualization, the machine gate open and the hypervisor gate shut
    assert_virt_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc && rsp_cause == CAUSE_VIRT) |->
        (req_virt && state_q.en_m[GATE_BIT] && !state_q.en_h[GATE_BIT]));

    // R3: only the two defined causes ever leave the block
    assert_cause_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |-> (rsp_cause == CAUSE_ILL || rsp_cause == CAUSE_VIRT));

    // R10: state-enable registers never hold bits outside their two defined bits
    assert_enable_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.en_m | state_q.en_h | state_q.en_s) & ~EN_MASK) == '0);

    // R7: supervisor config never holds bits outside its fields
    assert_senv_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.env_s & ~ENV_LO_MASK) == '0);

    generate
        if (GATE_EN) begin : g_chk_gate
            // R3: a shut machine gate always wins with the illegal cause
            assert_machine_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_addr == A_ENV_S && !state_q.en_m[GATE_BIT])
                |-> (rsp_exc && rsp_cause == CAUSE_ILL));
        end else begin : g_chk_open
            // R2: without the gate nothing faults
            assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !rsp_exc);
        end
    endgenerate
endmodule

// File: tb/test_envcfg_gate_csr.sv
module test_envcfg_gate_csr;
    localparam int PERIOD = 10;
    localparam logic [63:0] LO_F  = 64'h0000_0000_0000_00F1;
    localparam logic [63:0] HI_F  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_priv = '0;
    logic        req_virt = 1'b0;
    logic        req_xlen64 = 1'b1;
    logic [63:0] rsp_rdata, open_rdata;
    logic        rsp_exc, open_exc;
    logic [4:0]  rsp_cause, open_cause;

    int n_checks = 0;
    int n_fail = 0;

    // bench model of the register contents
    logic [63:0] m_env_s = '0, m_env_h = '0, m_en_m = '0, m_en_h = '0, m_en_s = '0;

    always #(PERIOD/2) clk = ~clk;

    envcfg_gate_csr i_envcfg_gate_csr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_priv(req_priv),
        .req_virt(req_virt), .req_xlen64(req_xlen64),
        .rsp_rdata(rsp_rdata), .rsp_exc(rsp_exc), .rsp_cause(rsp_cause));

    envcfg_gate_csr #(.GATE_EN(1'b0)) i_open (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_priv(req_priv),
        .req_virt(req_virt), .req_xlen64(req_xlen64),
        .rsp_rdata(open_rdata), .rsp_exc(open_exc), .rsp_cause(open_cause));

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] n,
                                        input logic [63:0] m);
        return (o & ~m) | (n & m);
    endfunction

    // one access; expected results from the requirements
    task automatic acc(input logic [11:0] a, input bit wr, input logic [63:0] wd,
                       input logic [1:0] pv, input bit vt, input bit x64);
        bit is_env;
        logic [4:0] ec;
        string tag;
        logic [63:0] lane, rv, er;
        lane = x64 ? '1 : LOW32;
        is_env = (a == 12'h10A) || (a == 12'h60A) || (a == 12'h61A);
        ec = 5'd0;
        tag = "R11";
        if (is_env) begin
            if (!m_en_m[62]) begin ec = 5'd2; tag = "R3"; end
            else if (vt && !m_en_h[62]) begin ec = 5'd22; tag = "R4"; end
            else if (pv == 2'd0 && !m_en_s[62]) begin ec = 5'd2; tag = "R5"; end
            else if (a == 12'h10A) tag = "R7";
            else if (a == 12'h60A) tag = "R8";
            else tag = "R9";
        end else tag = "R10";
        case (a)
            12'h10A: rv = m_env_s & lane;
            12'h60A: rv = m_env_h & lane;
            12'h61A: rv = {32'b0, m_env_h[63:32]};
            12'h30C: rv = m_en_m & lane;
            12'h31C: rv = {32'b0, m_en_m[63:32]};
            12'h60C: rv = m_en_h & lane;
            12'h61C: rv = {32'b0, m_en_h[63:32]};
            12'h10C: rv = m_en_s & lane;
            default: rv = '0;
        endcase
        er = (ec != 0) ? 64'd0 : rv;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        req_priv = pv; req_virt = vt; req_xlen64 = x64;
        #1;
        check(rsp_exc == (ec != 0) && rsp_cause == ec, tag,
              {58'd0, rsp_exc, rsp_cause}, {58'd0, (ec != 0), ec});
        if (!wr) check(rsp_rdata == er, (ec != 0) ? "R6" : tag, rsp_rdata, er);
        if (is_env) check(!open_exc, "R2", {63'd0, open_exc}, 64'd0);
        if (wr && ec == 0) begin
            case (a)
                12'h10A: m_env_s = mrg(m_env_s, wd, LO_F & lane);
                12'h60A: m_env_h = mrg(m_env_h, wd, (LO_F | HI_F) & lane);
                12'h61A: m_env_h = mrg(m_env_h, {wd[31:0], 32'b0}, HI_F);
                12'h30C: m_en_m  = mrg(m_en_m, wd, HI_F & lane);
                12'h31C: m_en_m  = mrg(m_en_m, {wd[31:0], 32'b0}, HI_F);
                12'h60C: m_en_h  = mrg(m_en_h, wd, HI_F & lane);
                12'h61C: m_en_h  = mrg(m_en_h, {wd[31:0], 32'b0}, HI_F);
                12'h10C: m_en_s  = mrg(m_en_s, wd, HI_F & lane);
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic set_enables(input bit em, input bit eh, input bit es);
        acc(12'h30C, 1'b1, {1'b1, em, 62'h3FFF_FFFF_FFFF_FFFF}, 2'd3, 1'b0, 1'b1);
        acc(12'h60C, 1'b1, {1'b0, eh, 62'h0}, 2'd3, 1'b0, 1'b1);
        acc(12'h10C, 1'b1, {1'b1, es, 62'h1234}, 2'd3, 1'b0, 1'b1);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [11:0] tgts [3];
        logic [63:0] seed;
        tgts[0] = 12'h10A; tgts[1] = 12'h60A; tgts[2] = 12'h61A;
        seed = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values of every register
        acc(12'h30C, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h60C, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h10C, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h10A, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        set_enables(1'b1, 1'b1, 1'b1);
        acc(12'h10A, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h60A, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        check(rsp_rdata == 64'd0, "R1", rsp_rdata, 64'd0);
        // R10: high-half writes and ignored bits
        acc(12'h61C, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b0);
        acc(12'h60C, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h31C, 1'b1, 64'h0000_0000_4000_0000, 2'd3, 1'b0, 1'b0);
        acc(12'h30C, 1'b0, '0, 2'd3, 1'b0, 1'b1);
        acc(12'h31C, 1'b0, '0, 2'd3, 1'b0, 1'b0);
        // sweep enables x xlen x privilege x virt x target
        for (int x = 0; x < 2; x++) begin
            for (int e = 0; e < 8; e++) begin
                set_enables(e[2], e[1], e[0]);
                for (int p = 0; p < 3; p++) begin
                    for (int v = 0; v < 2; v++) begin
                        logic [1:0] pv;
                        pv = (p == 2) ? 2'd3 : p[1:0];
                        if (pv == 2'd3 && v == 1) continue;
                        for (int t = 0; t < 3; t++) begin
                            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
                            acc(tgts[t], 1'b1, seed, pv, v[0], x[0]);
                            acc(tgts[t], 1'b0, '0, pv, v[0], x[0]);
                        end
                    end
                end
                // R6: open all gates and confirm earlier faulting writes left nothing behind
                set_enables(1'b1, 1'b1, 1'b1);
                for (int t = 0; t < 3; t++) acc(tgts[t], 1'b0, '0, 2'd3, 1'b0, 1'b1);
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule